// File: doc/BRIEF.md
# Quad-Channel Serial Write Front-End with Double-Buffered Converter Registers

This block receives a chip-select-framed serial bit stream and loads ten-bit words for four converter channels. Each channel has two register stages: a staging (input) register that the serial stream writes, and an output register that drives the converter. A frame can target one channel or all four in order. The frame's instruction decides whether the output registers follow at the close of the frame. Otherwise they follow later, when a separate active-low strobe falls while chip select is inactive. The output registers drive the converter cores directly.

All logic runs on the serial clock. The data line and chip select are sampled on its rising edge. The update strobe passes through a synchronizer and an edge detector. The reset input is asynchronous and active low, and it is released synchronously. A power-event flag reads low after reset and goes high at the first clock edge that sees chip select low. A host can use the flag to tell whether the converter contents are still trustworthy.

Top module: `qdac_wr_front`

## Requirements
- R1: While chip select is low and no frame is in progress, zeros on the data line are ignored; the frame begins at the first sampled 1 (the start bit).
- R2: A single-channel write is start=1, dir=0, all=0, upd, then two address bits sent high bit first that give channel index 0 to 3. Ten data bits follow, most significant first, and they go into that channel's staging register.
- R3: A group write is start=1, dir=0, all=1, upd, with no address bits. Four ten-bit words follow and fill staging registers 0, 1, 2 and 3 in that order.
- R4: With upd=0, no output register changes when the frame closes; only staging registers change.
- R5: A single-channel write with upd=1 loads the addressed output register from its staging register at the first clock edge that samples chip select high. The other three output registers keep their values.
- R6: A group write with upd=1 loads all four output registers at the first clock edge that samples chip select high.
- R7: The close-of-frame update takes place only if chip select stays low for at least one clock edge after the edge that samples the last data bit. Without that extra edge, the staging write still holds but no output register loads.
- R8: If chip select rises before a data word is complete, the partial word is dropped. No staging register and no output register changes.
- R9: A falling edge on the update strobe, seen while chip select is high, copies all four staging registers into the output registers within SYNC_STAGES+1 clocks. A falling edge seen while chip select is low has no effect.
- R10: A frame whose dir bit is 1 (a read request) is ignored until chip select rises. No register changes.
- R11: Reset clears all four output registers to zero and drives the power-event flag low.
- R12: The power-event flag goes high at the first clock edge that samples chip select low. It then stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all sampling on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select that frames a transfer |
| sdi | input | 1 | Serial data in |
| au_n | input | 1 | Active-low update strobe; a falling edge copies staging to output |
| pwr_flag_n | output | 1 | Power-event flag, low after reset |
| dac_word | output | NCH*WORD_W (40) | Output registers; channel i at bits [i*WORD_W +: WORD_W] |

## Verification
The assertions assume that chip select and the data line change only between rising clock edges, so each sampled value is settled. They also assume the update strobe has no glitches. The bench meets both conditions by driving every input on the falling clock edge. It holds each strobe pulse low for more than SYNC_STAGES clocks so the synchronizer always sees it. It never sends a strobe edge during the clock in which chip select rises, so a close-of-frame update and a strobe copy never compete in the checks.

// File: rtl/qdw_pkg.sv
package qdw_pkg;

  // Frame sequencer states
  typedef enum logic [2:0] {
    FS_IDLE,   // waiting for start bit
    FS_INSTR,  // collecting instruction bits
    FS_DATA,   // shifting data words
    FS_DONE,   // last word taken, waiting for the hold edge
    FS_ARMED,  // hold edge seen, update allowed at close
    FS_SKIP    // read request or unsupported: ignore until close
  } frame_st_e;

endpackage

// File: rtl/qdw_frame_ctl.sv
module qdw_frame_ctl
  import qdw_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int WORD_W = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      sdi,
  output logic                      wr_en,
  output logic [$clog2(NCH)-1:0]    wr_ch,
  output logic [WORD_W-1:0]         wr_data,
  output logic [NCH-1:0]            upd_mask
);

  localparam int ADDR_W = $clog2(NCH);
  localparam int BCW    = $clog2(WORD_W);
  localparam int ICW    = $clog2(ADDR_W + 4);
  localparam logic [ICW-1:0]    LAST_IBIT = ICW'(2 + ADDR_W);
  localparam logic [BCW-1:0]    LAST_BIT  = BCW'(WORD_W - 1);
  localparam logic [ADDR_W-1:0] LAST_CH   = ADDR_W'(NCH - 1);

  frame_st_e           st_q,   st_d;
  logic [ICW-1:0]      ibit_q, ibit_d;
  logic                glob_q, glob_d;
  logic                upd_q,  upd_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [ADDR_W-1:0]   ch_q,   ch_d;
  logic [BCW-1:0]      bcnt_q, bcnt_d;
  logic [WORD_W-1:0]   sh_q,   sh_d;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    ibit_d   = ibit_q;
    glob_d   = glob_q;
    upd_d    = upd_q;
    addr_d   = addr_q;
    ch_d     = ch_q;
    bcnt_d   = bcnt_q;
    sh_d     = sh_q;
    wr_en    = 1'b0;
    wr_ch    = ch_q;
    wr_data  = sh_q;
    upd_mask = '0;

    if (cs_n) begin
      st_d   = FS_IDLE;
      bcnt_d = '0;
      if (st_q == FS_ARMED && upd_q) begin
        upd_mask = glob_q ? {NCH{1'b1}} : (NCH'(1) << ch_q);
      end
    end else begin
      unique case (st_q)
        FS_IDLE: begin
          if (sdi) begin
            st_d   = FS_INSTR;
            ibit_d = '0;
            addr_d = '0;
          end
        end
        FS_INSTR: begin
          ibit_d = ibit_q + ICW'(1);
          if (ibit_q == ICW'(0)) begin
            if (sdi) st_d = FS_SKIP;
          end else if (ibit_q == ICW'(1)) begin
            glob_d = sdi;
          end else if (ibit_q == ICW'(2)) begin
            upd_d = sdi;
            if (glob_q) begin
              st_d   = FS_DATA;
              ch_d   = '0;
              bcnt_d = '0;
            end
          end else begin
            addr_d = (addr_q << 1) | ADDR_W'(sdi);
            if (ibit_q == LAST_IBIT) begin
              st_d   = FS_DATA;
              ch_d   = addr_d;
              bcnt_d = '0;
            end
          end
        end
        FS_DATA: begin
          sh_d   = {sh_q[WORD_W-2:0], sdi};
          bcnt_d = bcnt_q + BCW'(1);
          if (bcnt_q == LAST_BIT) begin
            wr_en   = 1'b1;
            wr_data = sh_d;
            bcnt_d  = '0;
            if (glob_q && ch_q != LAST_CH) begin
              ch_d = ch_q + ADDR_W'(1);
            end else begin
              st_d = FS_DONE;
            end
          end
        end
        FS_DONE:  st_d = FS_ARMED;
        FS_ARMED: st_d = FS_ARMED;
        FS_SKIP:  st_d = FS_SKIP;
        default:  st_d = FS_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      ibit_q <= '0;
      glob_q <= 1'b0;
      upd_q  <= 1'b0;
      addr_q <= '0;
      ch_q   <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
    end else begin
      st_q   <= st_d;
      ibit_q <= ibit_d;
      glob_q <= glob_d;
      upd_q  <= upd_d;
      addr_q <= addr_d;
      ch_q   <= ch_d;
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
    end
  end

endmodule

// File: rtl/qdw_strobe_sync.sv
module qdw_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall
);

  logic [STAGES-1:0] pipe_q, pipe_d;
  logic              prev_q, prev_d;

  always_comb begin
    if (STAGES > 1) pipe_d = {pipe_q[STAGES-2:0], strobe_n};
    else            pipe_d = STAGES'(strobe_n);
    prev_d = pipe_q[STAGES-1];
    fall   = prev_q & ~pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{1'b1}};
      prev_q <= 1'b1;
    end else begin
      pipe_q <= pipe_d;
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/qdw_chan_regs.sv
module qdw_chan_regs #(
  parameter int NCH    = 4,
  parameter int WORD_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [$clog2(NCH)-1:0] wr_ch,
  input  logic [WORD_W-1:0]      wr_data,
  input  logic [NCH-1:0]         upd_mask,
  input  logic                   load_all,
  output logic [NCH*WORD_W-1:0]  dac_word
);

  localparam int ADDR_W = $clog2(NCH);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [WORD_W-1:0] stg_q, stg_d;
    logic [WORD_W-1:0] out_q, out_d;
    logic              stg_en, out_en;

    always_comb begin
      stg_en = wr_en && (wr_ch == ADDR_W'(i));
      out_en = upd_mask[i] || load_all;
      stg_d  = stg_en ? wr_data : stg_q;
      out_d  = out_en ? stg_q   : out_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= '0;
        out_q <= '0;
      end else begin
        stg_q <= stg_d;
        out_q <= out_d;
      end
    end

    assign dac_word[i*WORD_W +: WORD_W] = out_q;
  end

endmodule

// File: rtl/qdac_wr_front.sv
module qdac_wr_front #(
  parameter int NCH         = 4,
  parameter int WORD_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sdi,
  input  logic                  au_n,
  output logic                  pwr_flag_n,
  output logic [NCH*WORD_W-1:0] dac_word
);

  localparam int ADDR_W = $clog2(NCH);

  // reset: asserted asynchronously, released on clock
  logic [1:0] rst_pipe_q, rst_pipe_d;
  logic       rst_sync_n;

  always_comb rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic                wr_en;
  logic [ADDR_W-1:0]   wr_ch;
  logic [WORD_W-1:0]   wr_data;
  logic [NCH-1:0]      upd_mask;
  logic                au_fall;
  logic                au_load;

  qdw_frame_ctl #(.NCH(NCH), .WORD_W(WORD_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cs_n     (cs_n),
    .sdi      (sdi),
    .wr_en    (wr_en),
    .wr_ch    (wr_ch),
    .wr_data  (wr_data),
    .upd_mask (upd_mask)
  );

  qdw_strobe_sync #(.STAGES(SYNC_STAGES)) u_au (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .strobe_n (au_n),
    .fall     (au_fall)
  );

  assign au_load = au_fall & cs_n;

  qdw_chan_regs #(.NCH(NCH), .WORD_W(WORD_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_ch    (wr_ch),
    .wr_data  (wr_data),
    .upd_mask (upd_mask),
    .load_all (au_load),
    .dac_word (dac_word)
  );

  // power-event flag
  logic pf_q, pf_d;

  always_comb pf_d = pf_q | ~cs_n;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pf_q <= 1'b0;
    else             pf_q <= pf_d;
  end

  assign pwr_flag_n = pf_q;

endmodule

// File: rtl/qdw_chk.sv
module qdw_chk #(
  parameter int NCH    = 4,
  parameter int WORD_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  pwr_flag_n,
  input logic [NCH*WORD_W-1:0] dac_word,
  input logic                  wr_en,
  input logic [NCH-1:0]        upd_mask,
  input logic                  au_load
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R11: assert (dac_word == '0 && !pwr_flag_n);
    end
  end

  assert_pf_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_flag_n |=> pwr_flag_n);

  assert_pf_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_flag_n) |-> $past(!cs_n));

  assert_out_quiet_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_word) |-> $past(cs_n));

  assert_stage_write_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cs_n);

  assert_close_update_at_cs_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_mask) |-> cs_n);

  assert_strobe_needs_cs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    au_load |-> cs_n);

endmodule

bind qdac_wr_front qdw_chk #(.NCH(NCH), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .pwr_flag_n (pwr_flag_n),
  .dac_word   (dac_word),
  .wr_en      (wr_en),
  .upd_mask   (upd_mask),
  .au_load    (au_load)
);

// File: tb/sim_qdac_wr_front.sv
module sim_qdac_wr_front;

  localparam int NCH = 4;
  localparam int WW  = 10;
  localparam int SYN = 2;

  logic clk = 1'b0;
  logic rst_n, cs_n, sdi, au_n;
  logic pwr_flag_n;
  logic [NCH*WW-1:0] dac_word;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  int stg_m [NCH];
  int out_m [NCH];

  always #4 clk = ~clk;

  qdac_wr_front #(.NCH(NCH), .WORD_W(WW), .SYNC_STAGES(SYN)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .au_n(au_n),
    .pwr_flag_n(pwr_flag_n), .dac_word(dac_word)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    for (int c = 0; c < NCH; c++) chk(req, int'(dac_word[c*WW +: WW]), out_m[c]);
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk); sdi = b;
  endtask

  task automatic put_bits(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic open_frame(input int idle_zeros);
    @(negedge clk); cs_n = 1'b0; sdi = 1'b0;
    for (int i = 0; i < idle_zeros; i++) put_bit(1'b0);
  endtask

  task automatic close_frame(input bit hold);
    if (hold) begin @(negedge clk); sdi = 1'b0; end
    @(negedge clk); cs_n = 1'b1; sdi = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe_pulse;
    @(negedge clk); au_n = 1'b0;
    repeat (SYN + 2) @(negedge clk);
    au_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) out_m[c] = stg_m[c];
  endtask

  task automatic write_one(input int ch, input bit upd, input int data,
                           input bit hold, input int idle_zeros);
    open_frame(idle_zeros);
    put_bits(4'b1000 | int'(upd), 4);  // start, dir=0, all=0, upd
    put_bits(ch, 2);
    put_bits(data, WW);
    stg_m[ch] = data;
    close_frame(hold);
    if (upd && hold) out_m[ch] = stg_m[ch];
  endtask

  task automatic write_all(input bit upd, input int d0, input int d1,
                           input int d2, input int d3);
    open_frame(0);
    put_bits(4'b1010 | int'(upd), 4);  // start, dir=0, all=1, upd
    put_bits(d0, WW); put_bits(d1, WW); put_bits(d2, WW); put_bits(d3, WW);
    stg_m[0] = d0; stg_m[1] = d1; stg_m[2] = d2; stg_m[3] = d3;
    close_frame(1'b1);
    if (upd) for (int c = 0; c < NCH; c++) out_m[c] = stg_m[c];
  endtask

  task automatic t_reset;
    chk_outs("R11 outputs after reset");
    chk("R11 flag low after reset", int'(pwr_flag_n), 0);
  endtask

  task automatic t_single_noupd;
    write_one(2, 1'b0, 10'h2A5, 1'b1, 0);
    chk_outs("R4 single upd=0 leaves outputs");
    chk("R12 flag high after CS low", int'(pwr_flag_n), 1);
    strobe_pulse();
    chk_outs("R2/R9 staged word copied by strobe");
  endtask

  task automatic t_single_upd;
    write_one(1, 1'b1, 10'h155, 1'b1, 3);
    chk_outs("R1/R5 single upd=1 after idle zeros");
  endtask

  task automatic t_group_upd;
    write_all(1'b1, 10'h3FF, 10'h001, 10'h200, 10'h0F0);
    chk_outs("R3/R6 group upd=1 order 0..3");
  endtask

  task automatic t_group_noupd;
    write_all(1'b0, 10'h123, 10'h234, 10'h345, 10'h056);
    chk_outs("R4 group upd=0 leaves outputs");
    strobe_pulse();
    chk_outs("R3/R9 group staged words copied");
    chk("R12 flag still high", int'(pwr_flag_n), 1);
  endtask

  task automatic t_no_hold;
    write_one(0, 1'b1, 10'h2C3, 1'b0, 0);
    chk_outs("R7 no hold edge no update");
    strobe_pulse();
    chk_outs("R7 staging still written");
  endtask

  task automatic t_partial;
    open_frame(0);
    put_bits(4'b1001, 4);
    put_bits(3, 2);
    put_bits(5'b10101, 5);
    close_frame(1'b1);
    chk_outs("R8 partial word no update");
    strobe_pulse();
    chk_outs("R8 partial word not staged");
  endtask

  task automatic t_read;
    open_frame(0);
    put_bits(4'b1100, 4);              // start, dir=1
    put_bits(32'hFFFF_FFFF, 26);
    close_frame(1'b1);
    chk_outs("R10 read request no output change");
    strobe_pulse();
    chk_outs("R10 read request no staging change");
  endtask

  task automatic t_strobe_cs_low;
    write_one(3, 1'b0, 10'h1E7, 1'b1, 0);
    @(negedge clk); cs_n = 1'b0; sdi = 1'b0;
    au_n = 1'b0;
    repeat (SYN + 2) @(negedge clk);
    au_n = 1'b1;
    repeat (SYN + 3) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_outs("R9 strobe with CS low ignored");
    strobe_pulse();
    chk_outs("R9 strobe with CS high copies");
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sdi = 1'b0; au_n = 1'b1;
    for (int c = 0; c < NCH; c++) begin stg_m[c] = 0; out_m[c] = 0; end
    repeat (3) @(negedge clk);
    chk("R11 flag low in reset", int'(pwr_flag_n), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single_noupd();
    t_single_upd();
    t_group_upd();
    t_group_noupd();
    t_no_hold();
    t_partial();
    t_read();
    t_strobe_cs_low();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule